// File: doc/BRIEF.md
# I2C Master Register and Transfer Controller

This block is the register bank and byte-level transfer sequencer that sits between a processor and a byte-oriented I2C bus engine. The processor reads and writes single bytes at a small set of offsets. Most offsets are plain storage, some of them masked. The status registers are cleared by writing ones. Three offsets also start bus work: the master data register, the control register and the low master address register.

Writing the data byte while the bus is idle opens a write transfer by itself, then sends that byte. Writing the control register with both the go bit and the read bit set closes any open transfer and opens a read. Each read of the data byte receives one byte from the engine. A two-bit pending field inside the control register counts down the remaining reads, and the controller closes and reopens the read between bytes while that field is nonzero. The engine takes one command pulse at a time and answers with a done pulse and an acknowledge. Any processor access that needs the engine is held with `cpuReady` low until all of its engine steps have finished.

Top module: `i2c_xfer_ctrl`

## Requirements
- R1: After reset every register reads 0x00, except extended status (offset 0x09), which reads 0x8F, and direct control (offset 0x10), which reads 0x0F.
- R2: Offsets 0x02, 0x05, 0x06, 0x0A, 0x0B, 0x0C, 0x0D, 0x0F (bit 0 clear) and 0x11 store the full written byte. Offsets 0x01, 0x03 and 0x12 to 0x1F read 0x00, and writes to them change nothing.
- R3: Mode control (0x07) stores the written value AND 0xDF, transfer count (0x0E) stores value AND 0x77, and direct control (0x10) stores value AND 0x07.
- R4: A write to status (0x08) clears only the written one-bits inside mask 0x0A. A write to extended status (0x09) clears only the written one-bits inside mask 0x8F.
- R5: A write to 0x0F with bit 0 set returns every register to its reset value, and the written byte is not stored.
- R6: A data write (0x00) while no transfer is open issues a start with `engRead`=0 to address bits [7:1] of offset 0x04. On acknowledge it sets status bit 0 (PT), clears status bit 2 (ERR), zeroes extended status, then sends the byte.
- R7: If that start is not acknowledged, PT is cleared, ERR is set, extended status bit 0 (abort) is set, and no byte is sent.
- R8: A sent byte that is not acknowledged clears PT, sets ERR and abort, and is followed by a stop.
- R9: A data write while a transfer is open sends the byte with no new start.
- R10: A control write (0x06) with bits 0 and 1 set clears PT, stops an open transfer, and starts a read. On acknowledge it sets status bit 5 (buffer full), clears ERR and zeroes extended status. On no acknowledge it sets ERR and abort. A control write with bit 0 set and bit 1 clear only clears PT.
- R11: A data read while buffer full is clear returns 0xFF and issues no engine command.
- R12: A data read while buffer full is set receives one byte and returns it. If control bits 5:4 are zero it clears buffer full, otherwise it stops and restarts the read. Either way it then decrements control bits 5:4, modulo 4.
- R13: A write to the low master address (0x04) stops an open transfer and issues no command when none is open.
- R14: At most one engine command pulses per cycle, each command waits for `engDone`, and `cpuReady` stays low while an access is waiting on the engine.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpuSel | input | 1 | Access request, held until accepted |
| cpuWr | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | ADDR_W | Byte offset |
| cpuWdata | input | 8 | Write data |
| cpuRdata | output | 8 | Read data, valid when cpuReady is high |
| cpuReady | output | 1 | Access completes on this edge |
| engStart | output | 1 | Start-with-address command pulse |
| engAddr | output | 7 | 7-bit target address |
| engRead | output | 1 | Direction for start |
| engSend | output | 1 | Send-byte command pulse |
| engTxByte | output | 8 | Byte to send |
| engRecv | output | 1 | Receive-byte command pulse |
| engStop | output | 1 | Stop command pulse |
| engDone | input | 1 | Command finished |
| engAck | input | 1 | Acknowledge for start or send |
| engRxByte | input | 8 | Received byte, valid with engDone |

## Verification
A wrong sequencer state shows at the engine pins within one command. A missing or extra start, send or stop changes the command counts that the engine model keeps, and this is seen as soon as the stalled access completes. A wrong flag update stays hidden until the status, extended status or control register is read back. For this reason every transfer is followed at once by read-backs of those registers. A wrong pending count shows on the next data read, either as an early 0xFF or as a missing restart.

// File: rtl/i2c_xfer_pkg.sv
package i2c_xfer_pkg;
  localparam int DATA_W = 8;

  localparam logic [4:0] OFS_MDATA = 5'h00;
  localparam logic [4:0] OFS_SDATA = 5'h02;
  localparam logic [4:0] OFS_LMADR = 5'h04;
  localparam logic [4:0] OFS_HMADR = 5'h05;
  localparam logic [4:0] OFS_CTRL  = 5'h06;
  localparam logic [4:0] OFS_MODE  = 5'h07;
  localparam logic [4:0] OFS_STAT  = 5'h08;
  localparam logic [4:0] OFS_XSTAT = 5'h09;
  localparam logic [4:0] OFS_LSADR = 5'h0A;
  localparam logic [4:0] OFS_HSADR = 5'h0B;
  localparam logic [4:0] OFS_CDIV  = 5'h0C;
  localparam logic [4:0] OFS_IMASK = 5'h0D;
  localparam logic [4:0] OFS_XCNT  = 5'h0E;
  localparam logic [4:0] OFS_XCTL  = 5'h0F;
  localparam logic [4:0] OFS_DCTL  = 5'h10;
  localparam logic [4:0] OFS_INTR  = 5'h11;

  localparam logic [7:0] XSTAT_RST = 8'h8F;
  localparam logic [7:0] DCTL_RST  = 8'h0F;

  localparam logic [7:0] MODE_MASK  = 8'hDF;
  localparam logic [7:0] XCNT_MASK  = 8'h77;
  localparam logic [7:0] DCTL_MASK  = 8'h07;
  localparam logic [7:0] STAT_W1C   = 8'h0A;
  localparam logic [7:0] XSTAT_W1C  = 8'h8F;

  localparam int CTL_GO   = 0;
  localparam int CTL_RD   = 1;
  localparam int PEND_LSB = 4;
  localparam int PEND_W   = 2;
  localparam int ST_PT    = 0;
  localparam int ST_ERR   = 2;
  localparam int ST_BUF   = 5;
  localparam int XS_ABORT = 0;

  typedef struct packed {
    logic setPt;
    logic clrPt;
    logic setErr;
    logic clrErr;
    logic setBuf;
    logic clrBuf;
    logic setAbort;
    logic clrExt;
    logic decPend;
    logic loadRx;
  } flagOps_t;

  typedef enum logic [3:0] {
    S_IDLE, S_STOP_REQ, S_STOP_WAIT, S_START_REQ, S_START_WAIT,
    S_SEND_REQ, S_SEND_WAIT, S_RECV_REQ, S_RECV_WAIT, S_FIN
  } seqState_t;

  typedef enum logic [1:0] {OP_WRITE, OP_RSTART, OP_RECV, OP_ADDR} opKind_t;
endpackage

// File: rtl/i2c_xfer_regs.sv
module i2c_xfer_regs
  import i2c_xfer_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  flagOps_t          ops,
  input  logic [DATA_W-1:0] rxByte,
  output logic [DATA_W-1:0] regRdata,
  output logic [DATA_W-1:0] rxHold,
  output logic [DATA_W-1:0] lmadrQ,
  output logic [DATA_W-1:0] mdataQ,
  output logic [DATA_W-1:0] statusQ,
  output logic [DATA_W-1:0] extQ,
  output logic              bufFull,
  output logic              pendZero
);
  localparam int OFS_W = 5;

  logic [DATA_W-1:0] sdataQ, hmadrQ, ctrlQ, modeQ, lsadrQ, hsadrQ;
  logic [DATA_W-1:0] cdivQ, imaskQ, xcntQ, xctlQ, dctlQ, intrQ;
  logic [DATA_W-1:0] ctrlNext, statusNext, extNext;
  logic [OFS_W-1:0]  ofs;
  logic              softRst;

  assign ofs     = OFS_W'(addr);
  assign softRst = wrEn && ofs == OFS_XCTL && wdata[0];

  always_comb begin
    ctrlNext = ctrlQ;
    if (wrEn && ofs == OFS_CTRL) ctrlNext = wdata;
    if (ops.decPend)
      ctrlNext[PEND_LSB +: PEND_W] = ctrlQ[PEND_LSB +: PEND_W] - PEND_W'(1);
  end

  always_comb begin
    statusNext = statusQ;
    if (wrEn && ofs == OFS_STAT) statusNext = statusQ & ~(wdata & STAT_W1C);
    if (wrEn && ofs == OFS_CTRL && wdata[CTL_GO] && !wdata[CTL_RD])
      statusNext[ST_PT] = 1'b0;
    if (ops.clrPt)  statusNext[ST_PT]  = 1'b0;
    if (ops.setPt)  statusNext[ST_PT]  = 1'b1;
    if (ops.clrErr) statusNext[ST_ERR] = 1'b0;
    if (ops.setErr) statusNext[ST_ERR] = 1'b1;
    if (ops.clrBuf) statusNext[ST_BUF] = 1'b0;
    if (ops.setBuf) statusNext[ST_BUF] = 1'b1;
  end

  always_comb begin
    extNext = extQ;
    if (wrEn && ofs == OFS_XSTAT) extNext = extQ & ~(wdata & XSTAT_W1C);
    if (ops.clrExt)   extNext = '0;
    if (ops.setAbort) extNext[XS_ABORT] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || softRst) begin
      mdataQ  <= '0;
      sdataQ  <= '0;
      lmadrQ  <= '0;
      hmadrQ  <= '0;
      ctrlQ   <= '0;
      modeQ   <= '0;
      statusQ <= '0;
      extQ    <= XSTAT_RST;
      lsadrQ  <= '0;
      hsadrQ  <= '0;
      cdivQ   <= '0;
      imaskQ  <= '0;
      xcntQ   <= '0;
      xctlQ   <= '0;
      dctlQ   <= DCTL_RST;
      intrQ   <= '0;
    end else begin
      ctrlQ   <= ctrlNext;
      statusQ <= statusNext;
      extQ    <= extNext;
      if (wrEn) begin
        case (ofs)
          OFS_MDATA: mdataQ <= wdata;
          OFS_SDATA: sdataQ <= wdata;
          OFS_LMADR: lmadrQ <= wdata;
          OFS_HMADR: hmadrQ <= wdata;
          OFS_MODE:  modeQ  <= wdata & MODE_MASK;
          OFS_LSADR: lsadrQ <= wdata;
          OFS_HSADR: hsadrQ <= wdata;
          OFS_CDIV:  cdivQ  <= wdata;
          OFS_IMASK: imaskQ <= wdata;
          OFS_XCNT:  xcntQ  <= wdata & XCNT_MASK;
          OFS_XCTL:  xctlQ  <= wdata;
          OFS_DCTL:  dctlQ  <= wdata & DCTL_MASK;
          OFS_INTR:  intrQ  <= wdata;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          rxHold <= '0;
    else if (ops.loadRx) rxHold <= rxByte;
  end

  always_comb begin
    case (ofs)
      OFS_MDATA: regRdata = '1;
      OFS_SDATA: regRdata = sdataQ;
      OFS_LMADR: regRdata = lmadrQ;
      OFS_HMADR: regRdata = hmadrQ;
      OFS_CTRL:  regRdata = ctrlQ;
      OFS_MODE:  regRdata = modeQ;
      OFS_STAT:  regRdata = statusQ;
      OFS_XSTAT: regRdata = extQ;
      OFS_LSADR: regRdata = lsadrQ;
      OFS_HSADR: regRdata = hsadrQ;
      OFS_CDIV:  regRdata = cdivQ;
      OFS_IMASK: regRdata = imaskQ;
      OFS_XCNT:  regRdata = xcntQ;
      OFS_XCTL:  regRdata = xctlQ;
      OFS_DCTL:  regRdata = dctlQ;
      OFS_INTR:  regRdata = intrQ;
      default:   regRdata = '0;
    endcase
  end

  assign bufFull  = statusQ[ST_BUF];
  assign pendZero = ctrlQ[PEND_LSB +: PEND_W] == '0;
endmodule

// File: rtl/i2c_xfer_seq.sv
module i2c_xfer_seq
  import i2c_xfer_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpuSel,
  input  logic              cpuWr,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [1:0]        ctlBits,
  input  logic              bufFull,
  input  logic              pendZero,
  input  logic              engDone,
  input  logic              engAck,
  output flagOps_t          ops,
  output logic              regWrEn,
  output logic              cpuReady,
  output logic              useRx,
  output logic              engStart,
  output logic              engRead,
  output logic              engSend,
  output logic              engRecv,
  output logic              engStop
);
  seqState_t state, stateNext;
  opKind_t   op, opNext;
  logic      busAct, busSet, busClr;
  logic      isDataWr, isRdStart, isDataRd, isAddrStop, needEng, idle;

  assign idle       = state == S_IDLE;
  assign isDataWr   = cpuWr && cpuAddr == ADDR_W'(OFS_MDATA);
  assign isRdStart  = cpuWr && cpuAddr == ADDR_W'(OFS_CTRL) && ctlBits[CTL_GO] && ctlBits[CTL_RD];
  assign isDataRd   = !cpuWr && cpuAddr == ADDR_W'(OFS_MDATA) && bufFull;
  assign isAddrStop = cpuWr && cpuAddr == ADDR_W'(OFS_LMADR) && busAct;
  assign needEng    = isDataWr || isRdStart || isDataRd || isAddrStop;

  assign regWrEn  = cpuSel && cpuWr && idle;
  assign cpuReady = (idle && !needEng) || state == S_FIN;
  assign useRx    = state == S_FIN && op == OP_RECV;

  assign engStart = state == S_START_REQ;
  assign engSend  = state == S_SEND_REQ;
  assign engRecv  = state == S_RECV_REQ;
  assign engStop  = state == S_STOP_REQ;
  assign engRead  = op != OP_WRITE;

  always_comb begin
    stateNext = state;
    opNext    = op;
    ops       = '0;
    busSet    = 1'b0;
    busClr    = 1'b0;
    case (state)
      S_IDLE: begin
        if (cpuSel && needEng) begin
          if (isDataWr) begin
            opNext    = OP_WRITE;
            stateNext = busAct ? S_SEND_REQ : S_START_REQ;
          end else if (isRdStart) begin
            opNext    = OP_RSTART;
            ops.clrPt = 1'b1;
            stateNext = busAct ? S_STOP_REQ : S_START_REQ;
          end else if (isDataRd) begin
            opNext    = OP_RECV;
            stateNext = S_RECV_REQ;
          end else begin
            opNext    = OP_ADDR;
            stateNext = S_STOP_REQ;
          end
        end
      end
      S_STOP_REQ:  stateNext = S_STOP_WAIT;
      S_STOP_WAIT: if (engDone) begin
        busClr    = 1'b1;
        stateNext = (op == OP_WRITE || op == OP_ADDR) ? S_FIN : S_START_REQ;
      end
      S_START_REQ:  stateNext = S_START_WAIT;
      S_START_WAIT: if (engDone) begin
        if (engAck) begin
          busSet     = 1'b1;
          ops.clrErr = 1'b1;
          ops.clrExt = 1'b1;
          if (op == OP_WRITE) begin
            ops.setPt = 1'b1;
            stateNext = S_SEND_REQ;
          end else begin
            ops.setBuf = 1'b1;
            stateNext  = S_FIN;
          end
        end else begin
          ops.clrPt    = 1'b1;
          ops.setErr   = 1'b1;
          ops.setAbort = 1'b1;
          stateNext    = S_FIN;
        end
      end
      S_SEND_REQ:  stateNext = S_SEND_WAIT;
      S_SEND_WAIT: if (engDone) begin
        if (engAck) stateNext = S_FIN;
        else begin
          ops.clrPt    = 1'b1;
          ops.setErr   = 1'b1;
          ops.setAbort = 1'b1;
          stateNext    = S_STOP_REQ;
        end
      end
      S_RECV_REQ:  stateNext = S_RECV_WAIT;
      S_RECV_WAIT: if (engDone) begin
        ops.loadRx = 1'b1;
        if (pendZero) begin
          ops.clrBuf = 1'b1;
          stateNext  = S_FIN;
        end else stateNext = S_STOP_REQ;
      end
      S_FIN: begin
        ops.decPend = op == OP_RECV;
        stateNext   = S_IDLE;
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      op     <= OP_WRITE;
      busAct <= 1'b0;
    end else begin
      state <= stateNext;
      op    <= opNext;
      if (busSet)      busAct <= 1'b1;
      else if (busClr) busAct <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_xfer_ctrl.sv
module i2c_xfer_ctrl
  import i2c_xfer_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpuSel,
  input  logic              cpuWr,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [7:0]        cpuWdata,
  output logic [7:0]        cpuRdata,
  output logic              cpuReady,
  output logic              engStart,
  output logic [6:0]        engAddr,
  output logic              engRead,
  output logic              engSend,
  output logic [7:0]        engTxByte,
  output logic              engRecv,
  output logic              engStop,
  input  logic              engDone,
  input  logic              engAck,
  input  logic [7:0]        engRxByte
);
  flagOps_t          ops;
  logic              regWrEn, useRx, bufFull, pendZero;
  logic [DATA_W-1:0] regRdata, rxHold, lmadrQ, mdataQ, statusQ, extQ;

  i2c_xfer_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .cpuSel(cpuSel), .cpuWr(cpuWr), .cpuAddr(cpuAddr),
    .ctlBits(cpuWdata[1:0]), .bufFull(bufFull), .pendZero(pendZero),
    .engDone(engDone), .engAck(engAck), .ops(ops), .regWrEn(regWrEn),
    .cpuReady(cpuReady), .useRx(useRx), .engStart(engStart), .engRead(engRead),
    .engSend(engSend), .engRecv(engRecv), .engStop(engStop)
  );

  i2c_xfer_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wrEn(regWrEn), .addr(cpuAddr), .wdata(cpuWdata),
    .ops(ops), .rxByte(engRxByte), .regRdata(regRdata), .rxHold(rxHold),
    .lmadrQ(lmadrQ), .mdataQ(mdataQ), .statusQ(statusQ), .extQ(extQ),
    .bufFull(bufFull), .pendZero(pendZero)
  );

  assign cpuRdata  = useRx ? rxHold : regRdata;
  assign engAddr   = lmadrQ[7:1];
  assign engTxByte = mdataQ;
endmodule

// File: rtl/i2c_xfer_chk.sv
module i2c_xfer_chk #(
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpuSel,
  input logic              cpuWr,
  input logic [ADDR_W-1:0] cpuAddr,
  input logic [7:0]        cpuWdata,
  input logic              cpuReady,
  input logic              engStart,
  input logic              engSend,
  input logic              engRecv,
  input logic              engStop,
  input logic [6:0]        engAddr,
  input logic [7:0]        statusQ,
  input logic [7:0]        extQ
);
  logic anyCmd;
  assign anyCmd = engStart | engSend | engRecv | engStop;

  AST_ONE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({engStart, engSend, engRecv, engStop})); // R14
  AST_CMD_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    anyCmd |-> !cpuReady); // R14
  AST_CMD_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    anyCmd |=> !anyCmd); // R14
  AST_ADDR_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (cpuSel && cpuWr && cpuAddr == ADDR_W'(5'h04) && cpuReady)
      |=> engAddr == $past(cpuWdata[7:1])); // R6
  AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (cpuSel && cpuWr && cpuAddr == ADDR_W'(5'h0F) && cpuWdata[0] && cpuReady)
      |=> (statusQ == 8'h00 && extQ == 8'h8F)); // R5
  AST_STATUS_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (cpuSel && cpuWr && cpuAddr == ADDR_W'(5'h08) && cpuReady)
      |=> (statusQ & $past(cpuWdata) & 8'h0A) == 8'h00); // R4
endmodule

bind i2c_xfer_ctrl i2c_xfer_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpuSel(cpuSel), .cpuWr(cpuWr), .cpuAddr(cpuAddr),
  .cpuWdata(cpuWdata), .cpuReady(cpuReady), .engStart(engStart), .engSend(engSend),
  .engRecv(engRecv), .engStop(engStop), .engAddr(engAddr), .statusQ(statusQ),
  .extQ(extQ)
);

// File: tb/i2c_xfer_ctrl_tb.sv
module i2c_xfer_ctrl_tb;
  localparam int ADDR_W = 5;
  localparam int LAT    = 3;
  localparam int NVEC   = 15;
  localparam logic [23:0] VEC [NVEC] = '{
    {8'h02, 8'hA5, 8'hA5}, {8'h05, 8'h3C, 8'h3C}, {8'h0A, 8'h12, 8'h12},
    {8'h0B, 8'h34, 8'h34}, {8'h0C, 8'h56, 8'h56}, {8'h0D, 8'h78, 8'h78},
    {8'h11, 8'h81, 8'h81}, {8'h0F, 8'h06, 8'h06}, {8'h07, 8'hFF, 8'hDF},
    {8'h0E, 8'hFF, 8'h77}, {8'h10, 8'hFF, 8'h07}, {8'h01, 8'h55, 8'h00},
    {8'h03, 8'hAA, 8'h00}, {8'h12, 8'h5A, 8'h00}, {8'h1F, 8'hC3, 8'h00}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpuSel = 1'b0, cpuWr = 1'b0;
  logic [ADDR_W-1:0] cpuAddr = '0;
  logic [7:0] cpuWdata = '0, cpuRdata;
  logic cpuReady, engStart, engRead, engSend, engRecv, engStop;
  logic [6:0] engAddr;
  logic [7:0] engTxByte;
  logic engDone = 1'b0, engAck = 1'b0;
  logic [7:0] engRxByte = '0;

  int checks = 0, errors = 0;
  int nStart = 0, nSend = 0, nRecv = 0, nStop = 0;
  logic [6:0] lastAddr = '0;
  logic lastRd = 1'b0;
  logic [7:0] lastTx = '0, rxCtr = 8'hC0;
  logic startAckV = 1'b1, sendAckV = 1'b1, pendAck = 1'b0;
  int engCnt = 0;
  int stallCyc;
  logic [7:0] rv;
  bit finished = 0;

  always #2 clk = ~clk;

  i2c_xfer_ctrl #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cpuSel(cpuSel), .cpuWr(cpuWr), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuRdata(cpuRdata), .cpuReady(cpuReady),
    .engStart(engStart), .engAddr(engAddr), .engRead(engRead), .engSend(engSend),
    .engTxByte(engTxByte), .engRecv(engRecv), .engStop(engStop),
    .engDone(engDone), .engAck(engAck), .engRxByte(engRxByte)
  );

  always @(posedge clk) begin
    engDone <= 1'b0;
    if (!rst_n) engCnt <= 0;
    else if (engCnt != 0) begin
      engCnt <= engCnt - 1;
      if (engCnt == 1) begin
        engDone <= 1'b1;
        engAck  <= pendAck;
      end
    end else if (engStart | engSend | engRecv | engStop) begin
      engCnt <= LAT;
      pendAck <= engStart ? startAckV : (engSend ? sendAckV : 1'b1);
      if (engStart) begin nStart <= nStart + 1; lastAddr <= engAddr; lastRd <= engRead; end
      if (engSend) begin nSend <= nSend + 1; lastTx <= engTxByte; end
      if (engStop) nStop <= nStop + 1;
      if (engRecv) begin nRecv <= nRecv + 1; engRxByte <= rxCtr; rxCtr <= rxCtr + 8'd1; end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [7:0] a, input logic [7:0] d,
                        output logic [7:0] rd);
    logic rdy;
    @(negedge clk);
    cpuSel = 1'b1; cpuWr = wr; cpuAddr = ADDR_W'(a); cpuWdata = d;
    stallCyc = 0;
    forever begin
      #1;
      rdy = cpuReady; rd = cpuRdata;
      @(posedge clk);
      if (rdy) break;
      stallCyc++;
      @(negedge clk);
    end
    @(negedge clk);
    cpuSel = 1'b0; cpuWr = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    logic [7:0] dummy;
    access(1'b1, a, d, dummy);
  endtask

  task automatic rdChk(input string req, input logic [7:0] a, input logic [7:0] exp);
    logic [7:0] v;
    access(1'b0, a, 8'h00, v);
    chk(req, v, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset values
    rdChk("R1 xstat", 8'h09, 8'h8F);
    rdChk("R1 dctl", 8'h10, 8'h0F);
    rdChk("R1 stat", 8'h08, 8'h00);
    rdChk("R1 ctrl", 8'h06, 8'h00);
    rdChk("R1 lmadr", 8'h04, 8'h00);

    // R2 R3 vector walk
    for (int i = 0; i < NVEC; i++) begin
      wr(VEC[i][23:16], VEC[i][15:8]);
      rdChk((VEC[i][7:0] != VEC[i][15:8]) ? "R3/R2 masked" : "R2 store",
            VEC[i][23:16], VEC[i][7:0]);
    end

    // R4 extended status W1C
    wr(8'h09, 8'h0F);  rdChk("R4 xstat low", 8'h09, 8'h80);
    wr(8'h09, 8'h70);  rdChk("R4 xstat unmasked", 8'h09, 8'h80);
    wr(8'h09, 8'h80);  rdChk("R4 xstat top", 8'h09, 8'h00);

    // R6 write transfer from idle
    wr(8'h04, 8'hA4);
    startAckV = 1'b1; sendAckV = 1'b1;
    wr(8'h00, 8'h3C);
    chk("R14 stall", int'(stallCyc >= 2 * LAT), 1);
    chk("R6 start", nStart, 1);
    chk("R6 addr", lastAddr, 7'h52);
    chk("R6 dir", lastRd, 0);
    chk("R6 send", nSend, 1);
    chk("R6 tx", lastTx, 8'h3C);
    rdChk("R6 stat", 8'h08, 8'h01);
    rdChk("R6 xstat", 8'h09, 8'h00);

    // R9 write while open
    wr(8'h00, 8'h5A);
    chk("R9 no start", nStart, 1);
    chk("R9 send", nSend, 2);
    chk("R9 tx", lastTx, 8'h5A);

    // R8 send nack
    sendAckV = 1'b0;
    wr(8'h00, 8'h77);
    chk("R8 stop", nStop, 1);
    rdChk("R8 stat", 8'h08, 8'h04);
    rdChk("R8 xstat", 8'h09, 8'h01);
    sendAckV = 1'b1;

    // R4 status W1C leaves ERR and PT
    wr(8'h08, 8'hFF);  rdChk("R4 stat", 8'h08, 8'h04);
    wr(8'h09, 8'h01);  rdChk("R4 xstat clr", 8'h09, 8'h00);

    // R7 start nack
    startAckV = 1'b0;
    wr(8'h00, 8'h11);
    chk("R7 start", nStart, 2);
    chk("R7 no send", nSend, 3);
    rdChk("R7 stat", 8'h08, 8'h04);
    rdChk("R7 xstat", 8'h09, 8'h01);

    // R10 go without read clears PT only
    startAckV = 1'b1;
    wr(8'h00, 8'h99);
    rdChk("R10 pre stat", 8'h08, 8'h01);
    wr(8'h06, 8'h01);
    rdChk("R10 pt clr", 8'h08, 8'h00);
    chk("R10 no start", nStart, 3);
    chk("R10 no stop", nStop, 1);

    // R10 read start with open bus, pending 2
    wr(8'h06, 8'h23);
    chk("R10 stop", nStop, 2);
    chk("R10 start", nStart, 4);
    chk("R10 dir", lastRd, 1);
    rdChk("R10 stat", 8'h08, 8'h20);
    rdChk("R10 xstat", 8'h09, 8'h00);

    // R12 reads with countdown
    rdChk("R12 byte0", 8'h00, 8'hC0);
    rdChk("R12 ctrl0", 8'h06, 8'h13);
    chk("R12 restart0", nStart, 5);
    rdChk("R12 byte1", 8'h00, 8'hC1);
    rdChk("R12 ctrl1", 8'h06, 8'h03);
    rdChk("R12 byte2", 8'h00, 8'hC2);
    rdChk("R12 ctrl wrap", 8'h06, 8'h33);
    rdChk("R12 buf clr", 8'h08, 8'h00);
    chk("R12 starts", nStart, 6);
    chk("R12 stops", nStop, 4);

    // R11 read with empty buffer
    rdChk("R11 ff", 8'h00, 8'hFF);
    chk("R11 no recv", nRecv, 3);

    // R10 read start nack
    startAckV = 1'b0;
    wr(8'h06, 8'h03);
    chk("R10 nack stop", nStop, 5);
    rdChk("R10 nack stat", 8'h08, 8'h04);
    rdChk("R10 nack xstat", 8'h09, 8'h01);

    // R13 address write stops open transfer only
    startAckV = 1'b1;
    wr(8'h00, 8'h42);
    wr(8'h04, 8'h40);
    chk("R13 stop", nStop, 6);
    chk("R6 new addr", engAddr, 7'h20);
    wr(8'h04, 8'h30);
    chk("R13 idle", nStop, 6);

    // R5 soft reset
    wr(8'h07, 8'h55);
    wr(8'h0F, 8'h01);
    rdChk("R5 mode", 8'h07, 8'h00);
    rdChk("R5 xctl", 8'h0F, 8'h00);
    rdChk("R5 xstat", 8'h09, 8'h8F);
    rdChk("R5 dctl", 8'h10, 8'h0F);
    rdChk("R5 stat", 8'h08, 8'h00);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule